// File: doc/BRIEF.md
# Periodic Battery-Check Flag Controller

This block decides when the backup battery of a clock/calendar chip gets tested and keeps the result as a sticky status flag. A test always runs as soon as main power is reported good. While main power stays good, further tests run each time a long interval expires, counted in 1 Hz ticks. No test is scheduled or run while the chip is on battery backup.

Each test raises a comparator-enable output for a fixed number of clock cycles. The comparator result is taken on the last of those cycles. A low result sets the battery-low flag, and only a later passing test clears it. A second bit records which kind of test produced the most recent low result. A low result from a power-up test means backed-up data may be corrupt. A low result from an interval test means the battery is wearing out but the data is still intact. Both bits are read through a small combinational register read port.

The controller is a three-state machine:

- **UNPOWERED** is entered from any state when power-good is sampled low.
- **UNPOWERED → MEASURE** happens when power-good is sampled high. This is a power-up test, and it also restarts the interval count.
- **IDLE → MEASURE** happens when the interval expires. This is an interval test.
- **MEASURE → IDLE** happens once the enable window has run out and the result has been sampled.
- **MEASURE → UNPOWERED** happens when power is lost during a test. The test is aborted and the flags do not change.

Top module: `batt_watch`

## Requirements
- R1: Whenever the state machine is in UNPOWERED and samples `pwr_good` high (this includes the first clock edge after reset), `cmp_en` is high from the following cycle on, and that test counts as a power-up test.
- R2: A test holds `cmp_en` high for exactly `SETTLE_CYCLES` consecutive cycles. `cmp_low` is sampled only at the clock edge that ends the last of those cycles. The new flag value is readable in the cycle after that edge.
- R3: While `pwr_good` is low, no test starts and ticks start none. `cmp_en` is low in the cycle after `pwr_good` is sampled low. A test interrupted this way leaves both status bits unchanged.
- R4: The interval count restarts at the start of each power-up test. An interval test starts at the edge that samples the `INTERVAL_TICKS`-th `tick_1hz` pulse counted while powered. `cmp_en` stays low before that pulse.
- R5: A test that samples `cmp_low` = 1 (battery below threshold) sets the low flag to 1.
- R6: The low flag is sticky. Changes on `cmp_low` outside a test's sampling edge have no effect. Only a test that samples `cmp_low` = 0 clears the flag.
- R7: The source bit is 1 when the most recent low result came from a power-up test and 0 when it came from an interval test. A passing test leaves it unchanged.
- R8: Reading address `FLAGS_ADDR` (default 0xF) returns the low flag in bit 4 and the source bit in bit 3, with bits 7..5 and 2..0 zero. Any other address reads 0x00. The read path is combinational.
- R9: During reset, `cmp_en` is low and both status bits are 0.
- R10: An interval expiry that falls inside a test is dropped, not queued. The next interval test comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_good | input | 1 | Main supply present (synchronous) |
| cmp_low | input | 1 | Comparator result, 1 = battery below threshold |
| cmp_en | output | 1 | Enables the battery comparator during a test |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, flags byte at `FLAGS_ADDR` |

## Verification
The bench drives random comparator values during the enable window and changes `cmp_low` after tests end. A design that samples early, samples late, or follows the comparator live would end up with the wrong flag.

Power is dropped in the middle of a test and ticks are then applied while unpowered. A design that commits a partial test, or keeps counting through backup, would change a flag or raise `cmp_en`.

A full interval of ticks is crowded into a power-up test. A design that queues the expiry would start an unexpected second test.

The bench also follows random sequences of power-up and interval tests with low and good results. This catches a source bit that is overwritten by passing tests or has the wrong polarity.

// File: rtl/batt_watch_pkg.sv
package batt_watch_pkg;

    typedef enum logic [1:0] {
        ST_UNPOWERED = 2'd0,
        ST_IDLE      = 2'd1,
        ST_MEASURE   = 2'd2
    } chk_state_e;

    typedef enum logic {
        SRC_INTERVAL = 1'b0,
        SRC_POWERUP  = 1'b1
    } chk_src_e;

    localparam int FLAG_LOW_BIT = 4;
    localparam int FLAG_SRC_BIT = 3;

endpackage

// File: rtl/batt_watch_interval.sv
module batt_watch_interval #(
    parameter int INTERVAL_TICKS = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_good,
    input  logic restart,
    output logic due
);
    localparam int CNT_W = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counts powered ticks; holds while on backup; restarts on power-up test.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (pwr_good && tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign due = pwr_good & tick & ~restart & (cnt_q == LAST);

endmodule

// File: rtl/batt_watch_fsm.sv
module batt_watch_fsm
    import batt_watch_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic due,
    input  logic cmp_low,
    output logic cmp_en,
    output logic restart,
    output logic low_flag,
    output logic src_bit
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] WIN_LAST = SW'(SETTLE_CYCLES - 1);

    chk_state_e     state_q, state_d;
    logic [SW-1:0]  win_q;
    chk_src_e       cur_src_q;
    logic           low_q, src_q;
    logic           sample_now, enter_meas;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNPOWERED;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNPOWERED: if (pwr_good) state_d = ST_MEASURE;
            ST_IDLE: begin
                if (!pwr_good) state_d = ST_UNPOWERED;
                else if (due)  state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!pwr_good)            state_d = ST_UNPOWERED;
                else if (win_q == '0)     state_d = ST_IDLE;
            end
            default: state_d = ST_UNPOWERED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        cmp_en     = (state_q == ST_MEASURE);
        restart    = (state_q == ST_UNPOWERED) && pwr_good;
        sample_now = (state_q == ST_MEASURE) && pwr_good && (win_q == '0);
        enter_meas = (state_d == ST_MEASURE) && (state_q != ST_MEASURE);
    end

    // Window counter, test source and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q     <= '0;
            cur_src_q <= SRC_INTERVAL;
            low_q     <= 1'b0;
            src_q     <= 1'b0;
        end else begin
            if (enter_meas) begin
                win_q     <= WIN_LAST;
                cur_src_q <= (state_q == ST_UNPOWERED) ? SRC_POWERUP : SRC_INTERVAL;
            end else if (state_q == ST_MEASURE && win_q != '0) begin
                win_q <= win_q - 1'b1;
            end
            if (sample_now) begin
                low_q <= cmp_low;
                if (cmp_low) src_q <= (cur_src_q == SRC_POWERUP);
            end
        end
    end

    assign low_flag = low_q;
    assign src_bit  = src_q;

endmodule

// File: rtl/batt_watch_regs.sv
module batt_watch_regs
    import batt_watch_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = '1
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              low_flag,
    input  logic              src_bit,
    output logic [7:0]        rd_data
);
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == FLAGS_ADDR) begin
            rd_data[FLAG_LOW_BIT] = low_flag;
            rd_data[FLAG_SRC_BIT] = src_bit;
        end
    end
endmodule

// File: rtl/batt_watch.sv
module batt_watch #(
    parameter int INTERVAL_TICKS = 86400,
    parameter int SETTLE_CYCLES  = 16,
    parameter int ADDR_W         = 4,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = ADDR_W'(15)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              pwr_good,
    input  logic              cmp_low,
    output logic              cmp_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic due, restart, low_flag, src_bit;

    batt_watch_interval #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .pwr_good (pwr_good),
        .restart  (restart),
        .due      (due)
    );

    batt_watch_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .due      (due),
        .cmp_low  (cmp_low),
        .cmp_en   (cmp_en),
        .restart  (restart),
        .low_flag (low_flag),
        .src_bit  (src_bit)
    );

    batt_watch_regs #(.ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR)) u_regs (
        .rd_addr  (rd_addr),
        .low_flag (low_flag),
        .src_bit  (src_bit),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/batt_watch_chk.sv
module batt_watch_chk #(
    parameter int SETTLE_CYCLES = 16,
    parameter int ADDR_W        = 4,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = ADDR_W'(15)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic              cmp_low,
    input logic              cmp_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              low_flag,
    input logic              src_bit
);
    int en_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_run <= 0;
        else if (cmp_en) en_run <= en_run + 1;
        else             en_run <= 0;
    end

    AST_PWRUP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |=> cmp_en); // R1
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (en_run < SETTLE_CYCLES)); // R2
    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmp_en) && $past(pwr_good)) |-> (en_run == SETTLE_CYCLES)); // R2
    AST_NO_EN_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !cmp_en); // R3
    AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_flag) |-> $past(cmp_low)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cmp_en) && $past(pwr_good)) |-> ($stable(low_flag) && $stable(src_bit))); // R6
    AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_flag) |-> !$past(cmp_low)); // R6
    AST_SRC_KEPT_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmp_low) |-> $stable(src_bit)); // R7
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != FLAGS_ADDR) |-> (rd_data == 8'h00)); // R8
    AST_RD_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == FLAGS_ADDR) |-> ((rd_data & 8'hE7) == 8'h00 && rd_data[4] == low_flag && rd_data[3] == src_bit)); // R8

endmodule

bind batt_watch batt_watch_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .ADDR_W(ADDR_W),
    .FLAGS_ADDR(FLAGS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .cmp_low  (cmp_low),
    .cmp_en   (cmp_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .low_flag (low_flag),
    .src_bit  (src_bit)
);

// File: tb/batt_watch_test.sv
`timescale 1ns/1ps
module batt_watch_test;
    localparam int INTERVAL = 5;
    localparam int SETTLE   = 6;
    localparam int AW       = 4;
    localparam logic [AW-1:0] FADDR = 4'hF;

    logic clk = 0, rst_n = 0, tick_1hz = 0, pwr_good = 0, cmp_low = 0;
    logic cmp_en;
    logic [AW-1:0] rd_addr = FADDR;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    bit exp_flag = 0, exp_src = 0, powered = 0, done = 0;

    always #5 clk = ~clk;

    batt_watch #(.INTERVAL_TICKS(INTERVAL), .SETTLE_CYCLES(SETTLE),
                 .ADDR_W(AW), .FLAGS_ADDR(FADDR)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_good(pwr_good),
        .cmp_low(cmp_low), .cmp_en(cmp_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic bit next_flag(bit low);
        return low;
    endfunction

    function automatic bit next_src(bit src, bit low, bit pu);
        return low ? pu : src;
    endfunction

    function automatic logic [7:0] flags_byte(bit f, bit s);
        return {3'b000, f, s, 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        logic [AW-1:0] other;
        rd_addr = FADDR;
        #1;
        check(rd_data == flags_byte(exp_flag, exp_src), req, "flags byte",
              rd_data, flags_byte(exp_flag, exp_src));
        other = AW'($urandom_range(0, 14));
        rd_addr = other;
        #1;
        check(rd_data == 8'h00, "R8", "non-flag address reads zero", rd_data, 0);
        rd_addr = FADDR;
    endtask

    // Called at the negedge where cmp_en is expected high for the first time.
    task automatic measure(input bit low, input bit pu, input bit tick_burst,
                           input string req);
        bit en_ok = 1;
        for (int i = 0; i < SETTLE; i++) begin
            if (cmp_en !== 1'b1) en_ok = 0;
            cmp_low  = (i == SETTLE - 1) ? low : 1'($urandom);
            tick_1hz = (tick_burst && i < INTERVAL);
            @(negedge clk);
        end
        tick_1hz = 0;
        check(en_ok, "R2", "enable held for settle window", en_ok, 1);
        check(cmp_en == 1'b0, "R2", "enable drops after window", cmp_en, 0);
        exp_flag = next_flag(low);
        exp_src  = next_src(exp_src, low, pu);
        check_flags(req);
        for (int i = 0; i < 4; i++) begin
            cmp_low = 1'($urandom);
            @(negedge clk);
        end
        check_flags("R6");
    endtask

    task automatic powerup(input bit low, input bit burst);
        pwr_good = 0;
        @(negedge clk);
        pwr_good = 1;
        @(negedge clk);
        check(cmp_en == 1'b1, "R1", "power-up test starts", cmp_en, 1);
        powered = 1;
        measure(low, 1, burst, low ? "R5" : "R6");
        if (burst) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(cmp_en == 1'b0, "R10", "expiry in test not queued", cmp_en, 0);
            end
        end
    endtask

    task automatic interval(input bit low);
        for (int k = 1; k <= INTERVAL; k++) begin
            tick_1hz = 1;
            @(negedge clk);
            tick_1hz = 0;
            if (k < INTERVAL) begin
                check(cmp_en == 1'b0, "R4", "no test before interval", cmp_en, 0);
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
        end
        check(cmp_en == 1'b1, "R4", "interval test starts", cmp_en, 1);
        measure(low, 0, 0, low ? "R7" : "R6");
    endtask

    task automatic abort_test();
        bit en_seen = 0;
        pwr_good = 0;
        @(negedge clk);
        pwr_good = 1;
        @(negedge clk);
        cmp_low = ~exp_flag;
        @(negedge clk);
        pwr_good = 0;
        @(negedge clk);
        check(cmp_en == 1'b0, "R3", "enable off after power loss", cmp_en, 0);
        for (int i = 0; i < INTERVAL + 2; i++) begin
            tick_1hz = 1;
            cmp_low = 1'($urandom);
            @(negedge clk);
            if (cmp_en) en_seen = 1;
        end
        tick_1hz = 0;
        check(!en_seen, "R3", "no test while unpowered", en_seen, 0);
        check_flags("R3");
        powered = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        pwr_good = 1;
        repeat (3) @(negedge clk);
        check(cmp_en == 1'b0, "R9", "enable low in reset", cmp_en, 0);
        check_flags("R9");
        rst_n = 1;
        @(negedge clk);
        check(cmp_en == 1'b1, "R1", "test right after reset", cmp_en, 1);
        powered = 1;
        measure(1, 1, 0, "R5");
        interval(0);
        interval(1);
        powerup(0, 1);
        interval(1);
        abort_test();
        powerup(1, 0);
        for (int n = 0; n < 24; n++) begin
            int op = $urandom_range(0, 3);
            bit lo = 1'($urandom);
            if (!powered || op == 0) powerup(lo, 0);
            else if (op == 1)        abort_test();
            else                     interval(lo);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule